// File: doc/BRIEF.md
# PCIe Configuration Request Engine

This block lets software issue one PCIe configuration read or write at a time over a small 32-bit register bus. Software first loads a request type, a 64-bit target address split into low and high words, write data and a 4-bit byte-enable mask. It then writes the launch register. The engine presents the request to the link side through a valid/ready handshake and waits for a completion carrying a 3-bit code, an error flag and read data. It then reports the outcome through a status word, a read-data register and a sticky done flag. Software polls the launch register, which reads as busy, or waits for the interrupt line.

The status word does not simply copy the completion code. The outcome depends on the direction of the request. A completion of "unsupported" or "retry" is a success on a read and returns fixed substitute data. The same two codes are failures on a write. A set error flag turns an otherwise good completion into a failure. An optional cycle limit abandons a request that never completes.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, `req_valid` and `irq` are 0, and the status (+0x04), launch (+0x1C) and done (+0x20) registers read 0.
- R2: Writing 1 to +0x1C while idle raises `req_valid` in the next cycle and holds it until `req_ready`. The request carries `req_type` = control bits 3:0 (0x8/0x9 read type 0/1, 0xA/0xB write type 0/1), `req_addr` = {high word, low word with bits 1:0 forced to 0}, the write-data register and the strobe register (bits 3:0). The launch register reads 1 until the request finishes.
- R3: The status word has these fields: bit 0 is pass, bits 9:7 the completion code, bit 10 non-posted (1 for every config type), bit 11 the completion error flag, bit 12 overlap, bit 13 timeout and bit 14 unknown. Code 0 passes only with the error flag clear, and a read that passes loads `cpl_data` into the read-data register (+0x18).
- R4: On a read, code 1 passes and loads 0xFFFFFFFF. Code 2 passes and loads 0xFFFF0001.
- R5: Codes 1 and 2 fail on a write. Code 4 fails in both directions. Codes 3, 5, 6 and 7 fail and set the unknown bit. A failed read loads 0xFFFFFFFF, and a write never changes the read-data register.
- R6: The done flag (+0x20 bit 0) sets exactly one cycle after the cycle in which the completion is accepted, and the launch register drops to 0 on that same edge. Writing 1 to bit 0 of +0x20 clears the done flag.
- R7: A launch write while busy issues no request and sets the overlap bit. The overlap bit stays set until 1 is written to status bit 12. Writes to the control, address, data and strobe registers are ignored while busy.
- R8: With a nonzero limit in +0x28, a request that has gone that many cycles without a completion is abandoned. The result is pass 0, unknown 1, timeout 1 and code 7. A limit of 0 disables the timeout.
- R9: When a done-clear write lands on the same edge that sets the done flag, the flag ends up set.
- R10: `irq` equals the done flag while mask bit 0 at +0x24 is 0, and `irq` is 0 while that mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Register access this cycle |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Byte address of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Done interrupt after masking |
| req_valid | output | 1 | Request offered to the link |
| req_ready | input | 1 | Link takes the request |
| req_type | output | 4 | Request type code |
| req_addr | output | 64 | Target address |
| req_wdata | output | 32 | Write payload |
| req_strb | output | 4 | Byte enables |
| cpl_valid | input | 1 | Completion present |
| cpl_code | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error flag |
| cpl_data | input | 32 | Completion read data |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is the completion-finish step that sets the done flag and a software write that clears it. The bench holds the done flag set from an earlier request and drives the clear write in the finishing cycle, then expects the flag to remain set. The second pair is a launch write and the finish step. The bench drives a launch write in the finishing cycle and expects the overlap bit, with no new request on the link.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;

    // register offsets inside the block window (software depends on these)
    localparam logic [5:0] OFF_CTRL = 6'h00;
    localparam logic [5:0] OFF_STAT = 6'h04;
    localparam logic [5:0] OFF_ALO  = 6'h08;
    localparam logic [5:0] OFF_AHI  = 6'h0C;
    localparam logic [5:0] OFF_WDAT = 6'h10;
    localparam logic [5:0] OFF_STRB = 6'h14;
    localparam logic [5:0] OFF_RDAT = 6'h18;
    localparam logic [5:0] OFF_GO   = 6'h1C;
    localparam logic [5:0] OFF_ISR  = 6'h20;
    localparam logic [5:0] OFF_IMSK = 6'h24;
    localparam logic [5:0] OFF_TMO  = 6'h28;

    // completion codes
    localparam logic [2:0] CPL_OK  = 3'd0;
    localparam logic [2:0] CPL_UR  = 3'd1;
    localparam logic [2:0] CPL_CRS = 3'd2;
    localparam logic [2:0] CPL_CA  = 3'd4;
    localparam logic [2:0] CPL_TMO = 3'd7;

    localparam logic [31:0] DATA_ALL1  = 32'hFFFF_FFFF;
    localparam logic [31:0] DATA_RETRY = 32'hFFFF_0001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_FIN  = 2'd3
    } eng_state_e;

    typedef struct packed {
        eng_state_e  state;
        logic [3:0]  rtype;
        logic [31:0] alo;
        logic [31:0] ahi;
        logic [31:0] wdat;
        logic [3:0]  strb;
        logic [31:0] rdat;
        logic [2:0]  code;
        logic        err;
        logic        np;
        logic        pass;
        logic        ovl;
        logic        tmo;
        logic        unk;
        logic        done;
        logic        imsk;
        logic [31:0] tlim;
        logic [2:0]  stg_code;
        logic        stg_err;
        logic [31:0] stg_data;
        logic        stg_tmo;
    } eng_regs_t;

endpackage

// File: rtl/cfg_pio_outcome.sv
// Maps a captured completion onto pass/unknown/result data, per direction.
module cfg_pio_outcome
    import cfg_pio_pkg::*;
(
    input  logic        is_wr,
    input  logic [2:0]  code_i,
    input  logic        err_i,
    input  logic        tmo_i,
    input  logic [31:0] data_i,
    output logic        pass_o,
    output logic        unk_o,
    output logic [2:0]  code_o,
    output logic [31:0] data_o
);
    always_comb begin
        pass_o = 1'b0;
        unk_o  = 1'b0;
        code_o = code_i;
        data_o = DATA_ALL1;
        if (tmo_i) begin
            unk_o  = 1'b1;
            code_o = CPL_TMO;
        end else begin
            case (code_i)
                CPL_OK: begin
                    pass_o = !err_i;
                    if (!err_i) data_o = data_i;
                end
                CPL_UR:  pass_o = !is_wr;
                CPL_CRS: begin
                    pass_o = !is_wr;
                    data_o = DATA_RETRY;
                end
                CPL_CA:  pass_o = 1'b0;
                default: unk_o  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/cfg_pio_timer.sv
// Counts cycles of an outstanding request; flags when the limit is reached.
module cfg_pio_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear)
            count_d = '0;
        else if (run && (count_q != {TMO_W{1'b1}}))
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expire = run && (limit != '0) && (count_q >= limit);
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
    import cfg_pio_pkg::*;
#(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h4000,
    parameter int              TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [3:0]        req_type,
    output logic [63:0]       req_addr,
    output logic [31:0]       req_wdata,
    output logic [3:0]        req_strb,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_code,
    input  logic              cpl_err,
    input  logic [31:0]       cpl_data
);
    localparam int OFF_W = 6;
    localparam logic [31:0] TMO_MASK =
        (TMO_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << TMO_W) - 32'd1);

    eng_regs_t d, q;

    logic        bus_hit;
    logic [5:0]  off;
    logic        idle;
    logic        launch;
    logic        tmo_hit;
    logic        oc_pass, oc_unk;
    logic [2:0]  oc_code;
    logic [31:0] oc_data;
    logic [31:0] rd_mux;

    // observation points for the bound checker
    eng_state_e  state_q;
    logic        done_q;
    logic        ovl_q;

    assign bus_hit = host_sel && (host_addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
    assign off     = host_addr[OFF_W-1:0];
    assign idle    = (q.state == ST_IDLE);
    assign launch  = bus_hit && host_we && (off == OFF_GO) && host_wdata[0] && idle;

    cfg_pio_timer #(.TMO_W(TMO_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (launch),
        .run    ((q.state == ST_REQ) || (q.state == ST_WAIT)),
        .limit  (q.tlim[TMO_W-1:0]),
        .expire (tmo_hit)
    );

    cfg_pio_outcome outcome_i (
        .is_wr  (q.rtype[1]),
        .code_i (q.stg_code),
        .err_i  (q.stg_err),
        .tmo_i  (q.stg_tmo),
        .data_i (q.stg_data),
        .pass_o (oc_pass),
        .unk_o  (oc_unk),
        .code_o (oc_code),
        .data_o (oc_data)
    );

    always_comb begin
        d = q;
        // host register writes
        if (bus_hit && host_we) begin
            case (off)
                OFF_CTRL: if (idle) d.rtype = host_wdata[3:0];
                OFF_ALO:  if (idle) d.alo   = host_wdata;
                OFF_AHI:  if (idle) d.ahi   = host_wdata;
                OFF_WDAT: if (idle) d.wdat  = host_wdata;
                OFF_STRB: if (idle) d.strb  = host_wdata[3:0];
                OFF_STAT: if (host_wdata[12]) d.ovl = 1'b0;
                OFF_GO: begin
                    if (host_wdata[0]) begin
                        if (idle) d.state = ST_REQ;
                        else      d.ovl   = 1'b1;
                    end
                end
                OFF_ISR:  if (host_wdata[0]) d.done = 1'b0;
                OFF_IMSK: d.imsk = host_wdata[0];
                OFF_TMO:  d.tlim = host_wdata & TMO_MASK;
                default: ;
            endcase
        end
        // request sequencing; the finish step wins over a done-clear
        case (q.state)
            ST_REQ: begin
                if (tmo_hit) begin
                    d.stg_tmo = 1'b1;
                    d.state   = ST_FIN;
                end else if (req_ready) begin
                    d.state   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cpl_valid) begin
                    d.stg_code = cpl_code;
                    d.stg_err  = cpl_err;
                    d.stg_data = cpl_data;
                    d.stg_tmo  = 1'b0;
                    d.state    = ST_FIN;
                end else if (tmo_hit) begin
                    d.stg_tmo  = 1'b1;
                    d.state    = ST_FIN;
                end
            end
            ST_FIN: begin
                d.code  = oc_code;
                d.err   = q.stg_tmo ? 1'b0 : q.stg_err;
                d.pass  = oc_pass;
                d.unk   = oc_unk;
                d.tmo   = q.stg_tmo;
                d.np    = q.rtype[3];
                if (!q.rtype[1]) d.rdat = oc_data;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // register read mux
    always_comb begin
        case (off)
            OFF_CTRL: rd_mux = {28'h0, q.rtype};
            OFF_STAT: rd_mux = {17'h0, q.unk, q.tmo, q.ovl, q.err, q.np,
                                q.code, 6'h0, q.pass};
            OFF_ALO:  rd_mux = q.alo;
            OFF_AHI:  rd_mux = q.ahi;
            OFF_WDAT: rd_mux = q.wdat;
            OFF_STRB: rd_mux = {28'h0, q.strb};
            OFF_RDAT: rd_mux = q.rdat;
            OFF_GO:   rd_mux = {31'h0, !idle};
            OFF_ISR:  rd_mux = {31'h0, q.done};
            OFF_IMSK: rd_mux = {31'h0, q.imsk};
            OFF_TMO:  rd_mux = q.tlim;
            default:  rd_mux = 32'h0;
        endcase
    end

    assign host_rdata = bus_hit ? rd_mux : 32'h0;
    assign irq        = q.done && !q.imsk;
    assign req_valid  = (q.state == ST_REQ);
    assign req_type   = q.rtype;
    assign req_addr   = {q.ahi, q.alo[31:2], 2'b00};
    assign req_wdata  = q.wdat;
    assign req_strb   = q.strb;

    assign state_q = q.state;
    assign done_q  = q.done;
    assign ovl_q   = q.ovl;
endmodule

// File: rtl/cfg_pio_checker.sv
module cfg_pio_checker
    import cfg_pio_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h4000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [31:0]       host_wdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [3:0]        req_type,
    input logic [63:0]       req_addr,
    input logic              tmo_hit,
    input eng_state_e        state_q,
    input logic              done_q,
    input logic              ovl_q
);
    logic wr_in_window;
    assign wr_in_window = host_sel && host_we &&
                          (host_addr[ADDR_W-1:6] == BASE[ADDR_W-1:6]);

    // R6: finish step leads to done set and idle on the next edge
    assert_done_after_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FIN |=> done_q && state_q == ST_IDLE);

    // R2: an offered request holds its contents until taken
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !tmo_hit |=>
            req_valid && $stable(req_addr) && $stable(req_type));

    // R7: no new request is offered while one is outstanding
    assert_no_second_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> !$rose(req_valid));

    // R7: overlap flag only falls after a clear write to status bit 12
    assert_ovl_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovl_q) |-> $past(wr_in_window && host_addr[5:0] == OFF_STAT && host_wdata[12]));

    // R6: done only falls after a clear write to the done register
    assert_done_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(wr_in_window && host_addr[5:0] == OFF_ISR && host_wdata[0]));

    // R8: timeout expiry moves straight to the finish step
    assert_timeout_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> state_q == ST_FIN);
endmodule

bind cfg_pio_engine cfg_pio_checker #(.ADDR_W(ADDR_W), .BASE(BASE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_addr   (req_addr),
    .tmo_hit    (tmo_hit),
    .state_q    (state_q),
    .done_q     (done_q),
    .ovl_q      (ovl_q)
);

// File: tb/cfg_pio_engine_tb_top.sv
module cfg_pio_engine_tb_top;
    import cfg_pio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [3:0]  req_type;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_code = '0;
    logic        cpl_err = 1'b0;
    logic [31:0] cpl_data = '0;

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] exp_rdat = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_pio_engine #(.ADDR_W(16), .BASE(BASE), .TMO_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_err(cpl_err),
        .cpl_data(cpl_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] o, input logic [31:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = BASE | {10'h0, o}; host_wdata = v;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] o, output logic [31:0] v);
        host_sel = 1'b1; host_we = 1'b0; host_addr = BASE | {10'h0, o};
        #1;
        v = host_rdata;
        host_sel = 1'b0;
    endtask

    function automatic logic [31:0] cfg_addr(input int bus, input int dev,
                                             input int fn, input int regn);
        return ((bus & 32'hFF) << 20) | ((dev & 32'h1F) << 15) |
               ((fn & 32'h7) << 12) | (regn & 32'hFFC);
    endfunction

    function automatic logic [3:0] size_strobe(input int size, input int offs);
        logic [7:0] m;
        m = ((8'd1 << size) - 8'd1) << offs;
        return m[3:0];
    endfunction

    function automatic void expect_res(input bit wr, input logic [2:0] cc, input bit ce,
                                       input logic [31:0] cd, output bit pass,
                                       output bit unk, output logic [31:0] rd);
        pass = 1'b0; unk = 1'b0; rd = 32'hFFFF_FFFF;
        case (cc)
            3'd0: begin pass = !ce; if (!ce) rd = cd; end
            3'd1: pass = !wr;
            3'd2: begin pass = !wr; rd = 32'hFFFF_0001; end
            3'd4: pass = 1'b0;
            default: unk = 1'b1;
        endcase
    endfunction

    task automatic launch(input logic [3:0] ty, input logic [31:0] alo, input logic [31:0] ahi,
                          input logic [31:0] wd, input logic [3:0] sb);
        logic [31:0] rv;
        bus_write(OFF_CTRL, {28'h0, ty});
        bus_write(OFF_ALO, alo);
        bus_write(OFF_AHI, ahi);
        bus_write(OFF_WDAT, wd);
        bus_write(OFF_STRB, {28'h0, sb});
        bus_write(OFF_GO, 32'h1);
        chk(req_valid === 1'b1 && req_type === ty, "R2 req_valid/type",
            {59'h0, req_valid, req_type}, {59'h1, ty});
        chk(req_addr === {ahi, alo[31:2], 2'b00}, "R2 req_addr", req_addr,
            {ahi, alo[31:2], 2'b00});
        chk(req_wdata === wd && req_strb === sb, "R2 data/strobe",
            {28'h0, req_strb, req_wdata}, {28'h0, sb, wd});
        bus_read(OFF_GO, rv);
        chk(rv === 32'h1, "R2 busy", {32'h0, rv}, 64'h1);
    endtask

    task automatic complete(input logic [2:0] cc, input bit ce, input logic [31:0] cd,
                            input int dly);
        @(negedge clk);
        repeat (dly) @(negedge clk);
        cpl_valid = 1'b1; cpl_code = cc; cpl_err = ce; cpl_data = cd;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic run_txn(input logic [3:0] ty, input logic [31:0] alo, input logic [31:0] ahi,
                           input logic [31:0] wd, input logic [3:0] sb, input logic [2:0] cc,
                           input bit ce, input logic [31:0] cd, input int dly);
        logic [31:0] rv, es;
        bit ep, eu, wr;
        logic [31:0] er;
        string tag;
        wr = ty[1];
        launch(ty, alo, ahi, wd, sb);
        complete(cc, ce, cd, dly);
        bus_read(OFF_ISR, rv);
        chk(rv === 32'h0, "R6 done not yet set", {32'h0, rv}, 64'h0);
        bus_read(OFF_GO, rv);
        chk(rv === 32'h1, "R6 busy in finish cycle", {32'h0, rv}, 64'h1);
        @(negedge clk);
        bus_read(OFF_ISR, rv);
        chk(rv === 32'h1, "R6 done set", {32'h0, rv}, 64'h1);
        bus_read(OFF_GO, rv);
        chk(rv === 32'h0, "R6 busy cleared", {32'h0, rv}, 64'h0);
        expect_res(wr, cc, ce, cd, ep, eu, er);
        if (!wr) exp_rdat = er;
        es = {17'h0, eu, 1'b0, 1'b0, ce, 1'b1, cc, 6'h0, ep};
        if (cc == 3'd0)                          tag = "R3 status";
        else if ((cc == 3'd1 || cc == 3'd2) && !wr) tag = "R4 status";
        else                                     tag = "R5 status";
        bus_read(OFF_STAT, rv);
        chk(rv === es, tag, {32'h0, rv}, {32'h0, es});
        bus_read(OFF_RDAT, rv);
        chk(rv === exp_rdat, wr ? "R5 read data untouched by write" : "R4 read data",
            {32'h0, rv}, {32'h0, exp_rdat});
        bus_write(OFF_ISR, 32'h1);
        bus_read(OFF_ISR, rv);
        chk(rv === 32'h0, "R6 done clear", {32'h0, rv}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_valid === 1'b0 && irq === 1'b0, "R1 outputs", {62'h0, req_valid, irq}, 64'h0);
        bus_read(OFF_STAT, rv); chk(rv === 32'h0, "R1 status", {32'h0, rv}, 64'h0);
        bus_read(OFF_GO, rv);   chk(rv === 32'h0, "R1 launch", {32'h0, rv}, 64'h0);
        bus_read(OFF_ISR, rv);  chk(rv === 32'h0, "R1 done", {32'h0, rv}, 64'h0);

        // directed reads covering each code (R3, R4, R5)
        run_txn(4'h8, cfg_addr(0, 0, 0, 12'h010), 32'h0, 32'h0, 4'hF, 3'd0, 1'b0, 32'hCAFE_0001, 0);
        run_txn(4'h9, cfg_addr(3, 5, 1, 12'h104) | 32'h3, 32'h0, 32'h0, 4'hF, 3'd0, 1'b1, 32'h1234_5678, 1);
        run_txn(4'h8, cfg_addr(1, 0, 0, 12'h000), 32'h0, 32'h0, 4'hF, 3'd1, 1'b0, 32'h0BAD_0BAD, 0);
        run_txn(4'h9, cfg_addr(2, 1, 2, 12'h008), 32'h0, 32'h0, 4'hF, 3'd2, 1'b0, 32'h0BAD_0BAD, 2);
        run_txn(4'h8, cfg_addr(2, 1, 2, 12'h008), 32'h0, 32'h0, 4'hF, 3'd4, 1'b0, 32'h0BAD_0BAD, 0);
        run_txn(4'h8, cfg_addr(2, 1, 2, 12'h00C), 32'h0, 32'h0, 4'hF, 3'd5, 1'b0, 32'h0BAD_0BAD, 0);
        // directed writes (R5)
        run_txn(4'hA, cfg_addr(0, 0, 0, 12'h004) | 32'h2, 32'h0, 32'hBEEF << 16,
                size_strobe(2, 2), 3'd1, 1'b0, 32'h0, 0);
        run_txn(4'hB, cfg_addr(4, 2, 0, 12'h040) | 32'h1, 32'h0, 32'h5A << 8,
                size_strobe(1, 1), 3'd2, 1'b0, 32'h0, 1);
        run_txn(4'hA, cfg_addr(0, 0, 0, 12'h010), 32'h0, 32'h1111_2222, 4'hF,
                3'd0, 1'b0, 32'h0, 0);

        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            logic [3:0] ty;
            int sz, offs;
            logic [31:0] alo, ahi, val;
            logic [2:0] cc;
            bit ce;
            ty   = 4'h8 + 4'($urandom % 4);
            sz   = (($urandom % 3) == 0) ? 1 : (($urandom % 2) == 0 ? 2 : 4);
            offs = (sz == 4) ? 0 : (sz == 2 ? 2 * int'($urandom % 2) : int'($urandom % 4));
            alo  = cfg_addr(int'($urandom % 256), int'($urandom % 32), int'($urandom % 8),
                            int'($urandom % 4096)) | 32'(offs);
            ahi  = (($urandom % 4) == 0) ? $urandom : 32'h0;
            val  = $urandom;
            cc   = 3'($urandom % 8);
            ce   = (($urandom % 4) == 0);
            if (ty[1])
                run_txn(ty, alo, ahi, val << (8 * offs), size_strobe(sz, offs),
                        cc, ce, 32'h0, int'($urandom % 3));
            else
                run_txn(ty, alo, ahi, 32'h0, 4'hF, cc, ce, $urandom, int'($urandom % 3));
        end

        // R7: launch while busy, register writes ignored while busy
        req_ready = 1'b0;
        launch(4'h8, cfg_addr(7, 3, 1, 12'h020), 32'h0, 32'h0, 4'hF);
        bus_write(OFF_CTRL, 32'hB);
        bus_write(OFF_ALO, 32'hFFFF_FFF0);
        bus_write(OFF_GO, 32'h1);
        chk(req_type === 4'h8 && req_addr[31:0] === cfg_addr(7, 3, 1, 12'h020),
            "R7 request kept", {28'h0, req_type, req_addr[31:0]},
            {28'h0, 4'h8, cfg_addr(7, 3, 1, 12'h020)});
        bus_read(OFF_STAT, rv);
        chk(rv[12] === 1'b1, "R7 overlap set", {32'h0, rv}, 64'h1000);
        req_ready = 1'b1;
        complete(3'd0, 1'b0, 32'h7777_0000, 0);
        @(negedge clk);
        chk(req_valid === 1'b0, "R7 no second request", {63'h0, req_valid}, 64'h0);
        bus_read(OFF_CTRL, rv);
        chk(rv === 32'h8, "R7 control ignored while busy", {32'h0, rv}, 64'h8);
        bus_read(OFF_STAT, rv);
        chk(rv[12] === 1'b1 && rv[0] === 1'b1, "R7 overlap sticky", {32'h0, rv}, 64'h1001);
        bus_write(OFF_STAT, 32'h1000);
        bus_read(OFF_STAT, rv);
        chk(rv[12] === 1'b0, "R7 overlap cleared", {32'h0, rv}, 64'h0);

        // R10: interrupt masking (done still set)
        chk(irq === 1'b1, "R10 irq follows done", {63'h0, irq}, 64'h1);
        bus_write(OFF_IMSK, 32'h1);
        chk(irq === 1'b0, "R10 irq masked", {63'h0, irq}, 64'h0);
        bus_write(OFF_IMSK, 32'h0);
        chk(irq === 1'b1, "R10 irq unmasked", {63'h0, irq}, 64'h1);

        // R9: done-clear and launch land on the finishing edge; done stays set
        launch(4'h8, cfg_addr(1, 1, 1, 12'h030), 32'h0, 32'h0, 4'hF);
        complete(3'd0, 1'b0, 32'h0000_9999, 0);
        host_sel = 1'b1; host_we = 1'b1; host_addr = BASE | {10'h0, OFF_ISR}; host_wdata = 32'h1;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
        bus_read(OFF_ISR, rv);
        chk(rv === 32'h1, "R9 set wins over clear", {32'h0, rv}, 64'h1);
        bus_read(OFF_RDAT, rv);
        chk(rv === 32'h0000_9999, "R9 read data", {32'h0, rv}, 64'h9999);
        bus_write(OFF_ISR, 32'h1);
        launch(4'h8, cfg_addr(1, 1, 1, 12'h034), 32'h0, 32'h0, 4'hF);
        complete(3'd0, 1'b0, 32'h0, 0);
        host_sel = 1'b1; host_we = 1'b1; host_addr = BASE | {10'h0, OFF_GO}; host_wdata = 32'h1;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
        chk(req_valid === 1'b0, "R9 launch in finish cycle ignored", {63'h0, req_valid}, 64'h0);
        bus_read(OFF_STAT, rv);
        chk(rv[12] === 1'b1, "R9 overlap from finish cycle", {32'h0, rv}, 64'h1000);
        bus_write(OFF_STAT, 32'h1000);
        bus_write(OFF_ISR, 32'h1);

        // R8: timeout with a silent completer
        bus_write(OFF_TMO, 32'd6);
        launch(4'h9, cfg_addr(9, 9, 1, 12'h0F0), 32'h0, 32'h0, 4'hF);
        repeat (3) @(negedge clk);
        bus_read(OFF_GO, rv);
        chk(rv === 32'h1, "R8 still busy before limit", {32'h0, rv}, 64'h1);
        for (int k = 0; k < 40; k++) begin
            bus_read(OFF_ISR, rv);
            if (rv == 32'h1) break;
            @(negedge clk);
        end
        bus_read(OFF_ISR, rv);
        chk(rv === 32'h1, "R8 done after timeout", {32'h0, rv}, 64'h1);
        bus_read(OFF_STAT, rv);
        chk(rv === {17'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 6'h0, 1'b0},
            "R8 timeout status", {32'h0, rv},
            {32'h0, 17'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd7, 6'h0, 1'b0});
        bus_write(OFF_ISR, 32'h1);
        bus_write(OFF_TMO, 32'd0);
        run_txn(4'h8, cfg_addr(0, 1, 0, 12'h000), 32'h0, 32'h0, 4'hF, 3'd0, 1'b0,
                32'hA5A5_5A5A, 12);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule